// File: doc/BRIEF.md
# Static 3½-Digit LCD Segment Driver

This block turns a signed decimal reading into the drive waveforms for a static (one backplane) liquid crystal panel with three full seven-segment digits, a leading half digit that can only show "1", and a minus sign. A free-running divider derived from the oscillator clock produces a 50% duty backplane square wave. Every segment line is a logic-level copy of that square wave. A lit segment carries the inverted copy and a dark segment carries the same copy. The panel therefore sees no net DC in normal operation.

The reading is captured into an internal pattern register only on the clock edge that flips the backplane. All segment lines therefore move on exactly the same edge as the backplane, and a reading that changes mid-phase never produces a partial phase. A lamp-test input overrides everything: the backplane is parked low and every segment line is parked high. All segments and the sign then light with a steady level, and the panel reads -1888.

Top module: `lcd_static_drv`

## Requirements
- R1: The backplane output flips once every DIV/2 clock cycles (default DIV = 800, so 400 cycles per half period), giving a 50% duty square wave at the clock frequency divided by DIV.
- R2: While rst_n is low, the backplane and every segment output are 0. The first backplane flip comes DIV/2 rising edges after reset is released.
- R3: Outside test mode, a lit segment's output is the inverse of the backplane and a dark segment's output equals the backplane. Segment outputs change only on the edge where the backplane flips, because inputs are sampled on that edge.
- R4: Segment bus bit order is a = bit 0 through g = bit 6. Digits 0–9 light: 0 = 0x3F, 1 = 0x06, 2 = 0x5B, 3 = 0x4F, 4 = 0x66, 5 = 0x6D, 6 = 0x7D, 7 = 0x07, 8 = 0x7F, 9 = 0x6F.
- R5: A BCD code from 10 to 15 on any full digit lights none of that digit's segments.
- R6: The minus-sign output is lit when neg_i is 1 and dark when it is 0.
- R7: The half-digit output (both halves of the leading "1") is lit when thou_i is 1 and dark when it is 0.
- R8: One clock edge after test_i is sampled high, the backplane is held at 0 and every segment output, including sign and half digit, is held at 1 for as long as test_i stays high. The divider and pattern capture keep running, so the latest reading appears at the first backplane flip after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_i | input | 1 | Lamp test: all segments lit with DC drive |
| neg_i | input | 1 | Reading is negative |
| thou_i | input | 1 | Thousands digit (0 or 1) |
| dig_hund_i | input | 4 | Hundreds digit, BCD |
| dig_tens_i | input | 4 | Tens digit, BCD |
| dig_ones_i | input | 4 | Units digit, BCD |
| bp_o | output | 1 | Backplane square wave |
| seg_hund_o | output | 7 | Hundreds segments a..g (bit 0 = a) |
| seg_tens_o | output | 7 | Tens segments a..g (bit 0 = a) |
| seg_ones_o | output | 7 | Units segments a..g (bit 0 = a) |
| seg_thou_o | output | 1 | Half-digit "1" segments |
| seg_minus_o | output | 1 | Minus sign segment |

## Verification
The lamp-test override and the periodic pattern capture can land on the same clock edge. In that case the forced DC levels must win at the outputs while the new reading is still taken into the pattern register. The bench counts cycles from an observed backplane flip and raises test_i one cycle before the next flip, so test_q and the capture strobe take effect on the same edge. It then checks that the outputs are forced immediately and stay constant across a later flip. It changes the reading during the test window and, after release, requires the new pattern in the correct phase at the first flip.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    localparam int SEG_W   = 7;
    localparam int NUM_DIG = 3;

    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        logic minus;
        logic thou;
        seg_t hund;
        seg_t tens;
        seg_t ones;
    } pattern_t;

    localparam int PAT_W = $bits(pattern_t);
endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
    parameter int DIV = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_o,
    output logic tgl_o
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = $clog2(HALF > 1 ? HALF : 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bp;
    } bp_state_t;

    bp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.bp  = ~st_q.bp;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bp_o  = st_q.bp;
    assign tgl_o = (st_q.cnt == LAST);

    // R1: the backplane flips right after a strobe and holds otherwise
    p_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tgl_o |=> (bp_o != $past(bp_o)));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tgl_o |=> $stable(bp_o));
endmodule

// File: rtl/lcd_seg_dec.sv
module lcd_seg_dec
    import lcd_pkg::*;
(
    input  logic [3:0] bcd_i,
    output seg_t       seg_o
);
    always_comb begin
        unique case (bcd_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = '0;
        endcase
    end
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
    import lcd_pkg::*;
#(
    parameter int DIV = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_i,
    input  logic       neg_i,
    input  logic       thou_i,
    input  logic [3:0] dig_hund_i,
    input  logic [3:0] dig_tens_i,
    input  logic [3:0] dig_ones_i,
    output logic       bp_o,
    output logic [6:0] seg_hund_o,
    output logic [6:0] seg_tens_o,
    output logic [6:0] seg_ones_o,
    output logic       seg_thou_o,
    output logic       seg_minus_o
);
    typedef struct packed {
        pattern_t pat;
        logic     test;
    } drv_state_t;

    logic       bp;
    logic       tgl;
    logic [3:0] bcd [NUM_DIG];
    seg_t       dec [NUM_DIG];
    pattern_t   drive;
    drv_state_t st_d, st_q;

    lcd_bp_gen #(.DIV(DIV)) u_bp (
        .clk   (clk),
        .rst_n (rst_n),
        .bp_o  (bp),
        .tgl_o (tgl)
    );

    assign bcd[0] = dig_ones_i;
    assign bcd[1] = dig_tens_i;
    assign bcd[2] = dig_hund_i;

    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dec
        lcd_seg_dec u_dec (
            .bcd_i (bcd[i]),
            .seg_o (dec[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.test = test_i;
        if (tgl) begin
            st_d.pat.minus = neg_i;
            st_d.pat.thou  = thou_i;
            st_d.pat.hund  = dec[2];
            st_d.pat.tens  = dec[1];
            st_d.pat.ones  = dec[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive       = st_q.test ? pattern_t'({PAT_W{1'b1}})
                                   : (st_q.pat ^ pattern_t'({PAT_W{bp}}));
    assign bp_o        = bp & ~st_q.test;
    assign seg_minus_o = drive.minus;
    assign seg_thou_o  = drive.thou;
    assign seg_hund_o  = drive.hund;
    assign seg_tens_o  = drive.tens;
    assign seg_ones_o  = drive.ones;

    // R3: with no test activity and a steady backplane, segments stay put
    p_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.test && !$past(st_q.test) && $stable(bp_o)) |->
        ($stable(seg_ones_o) && $stable(seg_tens_o) && $stable(seg_hund_o)
         && $stable(seg_thou_o) && $stable(seg_minus_o)));

    // R5: an out-of-range units code captured at a flip leaves the digit dark
    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl && !test_i && dig_ones_i > 4'd9) |=> (seg_ones_o == {7{bp_o}}));

    // R6: a negative reading captured at a flip drives the sign in antiphase
    p_minus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl && !test_i && neg_i) |=> (seg_minus_o != bp_o));

    // R8: lamp test forces DC levels one edge later
    p_test_dc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        test_i |=> (!bp_o && seg_minus_o && seg_thou_o && (&seg_hund_o)
                    && (&seg_tens_o) && (&seg_ones_o)));
endmodule

// File: tb/lcd_static_drv_tb.sv
`timescale 1ns/1ps
module lcd_static_drv_tb;
    localparam int DIV  = 800;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_i = 1'b0, neg_i = 1'b0, thou_i = 1'b0;
    logic [3:0] dig_hund_i = '0, dig_tens_i = '0, dig_ones_i = '0;
    logic       bp_o, seg_thou_o, seg_minus_o;
    logic [6:0] seg_hund_o, seg_tens_o, seg_ones_o;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    lcd_static_drv #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_i(test_i), .neg_i(neg_i),
        .thou_i(thou_i), .dig_hund_i(dig_hund_i), .dig_tens_i(dig_tens_i),
        .dig_ones_i(dig_ones_i), .bp_o(bp_o), .seg_hund_o(seg_hund_o),
        .seg_tens_o(seg_tens_o), .seg_ones_o(seg_ones_o),
        .seg_thou_o(seg_thou_o), .seg_minus_o(seg_minus_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R4 and R5: font from the requirement table
    function automatic logic [6:0] font(input logic [3:0] d);
        case (d)
            4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
            4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
            4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
            4'd9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    function automatic logic [22:0] outs();
        return {seg_minus_o, seg_thou_o, seg_hund_o, seg_tens_o, seg_ones_o};
    endfunction

    // scoreboard state
    logic [22:0] q[$];
    logic [22:0] cur = '0;
    bit          mon_en = 1'b0, skip = 1'b0;
    logic        prev_bp = 1'b0;
    int          cyc = 0;
    event        ev_tgl;

    always @(negedge clk) begin
        if (mon_en) begin
            logic [22:0] obs;
            cyc++;
            obs = outs() ^ {23{bp_o}};
            if (bp_o !== prev_bp) begin
                if (!skip) chk(cyc == HALF, "R1 half period", cyc, HALF);
                skip = 1'b0;
                cyc = 0;
                prev_bp = bp_o;
                if (q.size() > 0) cur = q.pop_front();
                chk(obs == cur, "R3/R4 pattern at flip", obs, cur);
                ->ev_tgl;
            end else if (!skip) begin
                chk(obs == cur, "R3 steady mid-phase", obs, cur);
            end
        end
    end

    task automatic set_reading(input bit wait_flip, input logic n, input logic t,
                               input logic [3:0] h, input logic [3:0] te,
                               input logic [3:0] o);
        if (wait_flip) begin
            @(ev_tgl);
            repeat (100) @(negedge clk);
        end
        neg_i = n; thou_i = t; dig_hund_i = h; dig_tens_i = te; dig_ones_i = o;
        q.push_back({n, t, font(h), font(te), font(o)}); // R5 R6 R7
    endtask

    task automatic run();
        repeat (3) @(negedge clk);
        chk(outs() == 23'd0 && bp_o == 1'b0, "R2 reset state", {bp_o, outs()}, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        prev_bp = 1'b0; cyc = 0; mon_en = 1'b1;
        set_reading(1'b0, 1'b1, 1'b1, 4'd1, 4'd2, 4'd3);
        for (int i = 0; i < 10; i++)
            set_reading(1'b1, 1'(i % 2), 1'(i % 3 == 0), 4'(i), 4'((i + 3) % 10),
                        4'((i + 7) % 10));
        set_reading(1'b1, 1'b0, 1'b0, 4'hA, 4'hF, 4'hC); // R5 blanking
        set_reading(1'b1, 1'b1, 1'b0, 4'd8, 4'hB, 4'd0); // R6 sign, R5 mixed
        set_reading(1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0); // R7 half digit
        @(ev_tgl);
        @(ev_tgl);
        // R8: raise test so it is registered on the same edge as the flip
        repeat (HALF - 1) @(negedge clk);
        test_i = 1'b1; mon_en = 1'b0;
        @(negedge clk);
        chk(outs() == '1 && bp_o == 1'b0, "R8 forced on coincident edge",
            {bp_o, outs()}, 23'h7FFFFF);
        set_reading(1'b0, 1'b1, 1'b0, 4'd9, 4'hE, 4'd5);
        for (int k = 0; k < 6; k++) begin
            repeat (100) @(negedge clk);
            chk(outs() == '1 && bp_o == 1'b0, "R8 DC held", {bp_o, outs()}, 23'h7FFFFF);
        end
        test_i = 1'b0;
        @(posedge clk);
        #1;
        prev_bp = bp_o; cyc = 0; skip = 1'b1; mon_en = 1'b1;
        @(ev_tgl);
        chk(q.size() == 0, "R8 pattern after release", q.size(), 0);
        @(ev_tgl);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule